// File: doc/BRIEF.md
# Two-Level PRG Bank Mapper

This block sits between a CPU bus and cartridge program memory. It watches CPU writes to the upper half of the 64 KB address space and uses them to load a small set of control registers. From those registers and the current CPU address it forms a program ROM address, a chip select for an 8 KB work-RAM window, a flag that tells the bus to keep its previous value when a read hits a disabled RAM, and a 2-bit nametable mirroring code for the video side.

Banking works on two levels. A one-bit outer select picks a 256 KB block of sixteen 16 KB banks. A four-bit inner select chooses which of those banks appears at 0x8000–0xBFFF. The 0xC000–0xFFFF window is fixed to the last bank of whichever outer block is selected, not to the last bank of the whole ROM. Writes to the three interval-timer slots are decoded here and passed on to a separate timer block through a strobe, a slot index and the data byte.

Top module: `prg_bank_mapper`

## Requirements
- R1: A write with cpu_addr[15] = 1 selects a register slot from cpu_addr[3:0] alone. Address bits [14:4] play no part, so 0xF008 acts exactly like 0x8008.
- R2: Slots 0, 1, 2 and 3 all load the same outer bank bit from data bit 0. Slots 4 to 7, 0xE and 0xF change no register.
- R3: Slot 8 loads the 4-bit inner bank from data bits [3:0].
- R4: When cpu_addr[14] = 0, rom_addr = {outer, inner, cpu_addr[13:0]}, which is bank outer×16+inner.
- R5: When cpu_addr[14] = 1, rom_addr = {outer, 4'hF, cpu_addr[13:0]}, which is bank outer×16+15.
- R6: Slot 9 loads mirror_mode from data bits [1:0]. The codes are 0 vertical, 1 horizontal, 2 single-screen lower and 3 single-screen upper.
- R7: Slot 0xD turns work RAM on when data bit 6 is 1 and off when bit 6 is 0.
- R8: For cpu_addr in 0x6000–0x7FFF, wram_cs = (cpu_rd | cpu_wr) & RAM-on. open_bus = cpu_rd & RAM-off in that window. Outside the window both signals are 0.
- R9: A write with cpu_addr[15] = 0 changes no register.
- R10: After reset the outer bank, inner bank, RAM-on and mirror_mode are all 0. Bank 0 then sits at 0x8000 and bank 15 at 0xC000.
- R11: A write to slot 0xA, 0xB or 0xC drives irq_wr high during the write cycle. irq_sel is 0, 1 or 2 respectively, and irq_wdata carries the data byte. For every other access irq_wr is 0.
- R12: A register write takes effect on the rising clock edge at which cpu_wr is high. During the write cycle rom_addr still reflects the previous register values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe |
| rom_addr | output | 19 | Banked program ROM byte address |
| wram_cs | output | 1 | Work-RAM select for the 0x6000–0x7FFF window |
| open_bus | output | 1 | Read hit a disabled work RAM; hold the bus value |
| mirror_mode | output | 2 | Nametable mirroring code |
| irq_wr | output | 1 | Write strobe toward the interval-timer block |
| irq_sel | output | 2 | Timer slot: 0 control, 1 reload low, 2 reload high |
| irq_wdata | output | 8 | Data byte for the timer block |

## Verification
The bench aims at these corner cases:
- **Aliased outer-bank slots.** A design that decoded only slot 0 would leave the high window stuck in block 0 after a write to slot 3.
- **Fixed high window.** A mapper that pinned the high window to the last bank of the whole ROM would output bank 31 while the outer bit is 0.
- **Full address decode.** Mirrored addresses such as 0xF008, and writes below 0x8000 that carry register-like low bits, catch a design that decodes more address bits than it should, or fewer.
- **RAM gating and timing.** Reads and writes to the RAM window with RAM-on in both states expose swapped or leaking chip-select and open-bus outputs. Sampling rom_addr inside the write cycle catches a design that forwards the new bank combinationally.

// File: rtl/prg_map_pkg.sv
package prg_map_pkg;
    localparam int CPU_AW   = 16;
    localparam int DATA_W   = 8;
    localparam int OUTER_W  = 1;
    localparam int INNER_W  = 4;
    localparam int WIN_AW   = 14;
    localparam int SLOT_W   = 4;
    localparam int ROM_AW   = OUTER_W + INNER_W + WIN_AW;
    localparam int BANK_W   = OUTER_W + INNER_W;

    localparam logic [SLOT_W-1:0] SLOT_INNER    = 4'h8;
    localparam logic [SLOT_W-1:0] SLOT_MIRROR   = 4'h9;
    localparam logic [SLOT_W-1:0] SLOT_TMR_CTRL = 4'hA;
    localparam logic [SLOT_W-1:0] SLOT_TMR_LO   = 4'hB;
    localparam logic [SLOT_W-1:0] SLOT_TMR_HI   = 4'hC;
    localparam logic [SLOT_W-1:0] SLOT_WRAM     = 4'hD;
    localparam int WRAM_EN_BIT = 6;

    typedef enum logic [1:0] {
        MIR_VERT   = 2'd0,
        MIR_HORZ   = 2'd1,
        MIR_ONE_LO = 2'd2,
        MIR_ONE_HI = 2'd3
    } mirror_e;

    typedef struct packed {
        logic [OUTER_W-1:0] outer;
        logic [INNER_W-1:0] inner;
        mirror_e            mirror;
        logic               wram_on;
    } map_state_t;
endpackage

// File: rtl/prg_map_decode.sv
module prg_map_decode
    import prg_map_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    output logic              reg_wr,
    output logic [SLOT_W-1:0] reg_slot,
    output logic              ram_win,
    output logic              ram_access,
    output logic              tmr_hit
);
    logic hi_half;

    always_comb begin
        hi_half    = cpu_addr[CPU_AW-1];
        reg_slot   = cpu_addr[SLOT_W-1:0];
        reg_wr     = cpu_wr && hi_half;
        ram_win    = (cpu_addr[CPU_AW-1:CPU_AW-3] == 3'b011);
        ram_access = ram_win && (cpu_rd || cpu_wr);
        tmr_hit    = reg_wr && (reg_slot >= SLOT_TMR_CTRL) && (reg_slot <= SLOT_TMR_HI);
    end

    // R9: no register strobe from the lower half
    a_r9_low_half_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_addr[CPU_AW-1] |-> !reg_wr);
    // R8: the RAM window never overlaps the register half
    a_r8_window_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
        ram_win |-> !reg_wr);
endmodule

// File: rtl/prg_map_regs.sv
module prg_map_regs
    import prg_map_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [SLOT_W-1:0] reg_slot,
    input  logic [DATA_W-1:0] wdata,
    output map_state_t        state_q
);
    map_state_t state_d;

    always_comb begin
        state_d = state_q;
        if (reg_wr) begin
            if (reg_slot[SLOT_W-1:2] == '0) begin
                state_d.outer = wdata[OUTER_W-1:0];
            end else begin
                unique case (reg_slot)
                    SLOT_INNER:  state_d.inner   = wdata[INNER_W-1:0];
                    SLOT_MIRROR: state_d.mirror  = mirror_e'(wdata[1:0]);
                    SLOT_WRAM:   state_d.wram_on = wdata[WRAM_EN_BIT];
                    default:     state_d = state_q;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // R2: every alias slot loads the outer bit
    a_r2_outer_alias: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_slot[SLOT_W-1:2] == '0) |=> state_q.outer == $past(wdata[OUTER_W-1:0]));
    // R3: inner bank load
    a_r3_inner_load: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_slot == SLOT_INNER) |=> state_q.inner == $past(wdata[INNER_W-1:0]));
    // R6: mirroring load
    a_r6_mirror_load: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_slot == SLOT_MIRROR) |=> state_q.mirror == $past(wdata[1:0]));
    // R7: RAM enable load
    a_r7_wram_load: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_slot == SLOT_WRAM) |=> state_q.wram_on == $past(wdata[WRAM_EN_BIT]));
    // R9: no strobe, no change
    a_r9_hold_state: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> $stable(state_q));
endmodule

// File: rtl/prg_map_addr.sv
module prg_map_addr
    import prg_map_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  map_state_t        state_q,
    input  logic [CPU_AW-1:0] cpu_addr,
    output logic [ROM_AW-1:0] rom_addr
);
    logic [BANK_W-1:0] bank;

    always_comb begin
        if (cpu_addr[WIN_AW]) begin
            bank = {state_q.outer, {INNER_W{1'b1}}};
        end else begin
            bank = {state_q.outer, state_q.inner};
        end
        rom_addr = {bank, cpu_addr[WIN_AW-1:0]};
    end

    // R5: high window always lands on the last bank of the outer block
    a_r5_fixed_last: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_addr[WIN_AW] |-> (&rom_addr[ROM_AW-OUTER_W-1:WIN_AW]));
    // R4: outer bit reaches the top of the ROM address
    a_r4_outer_top: assert property (@(posedge clk) disable iff (!rst_n)
        rom_addr[ROM_AW-1:ROM_AW-OUTER_W] == state_q.outer);
endmodule

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper
    import prg_map_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_wdata,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    output logic [18:0]       rom_addr,
    output logic              wram_cs,
    output logic              open_bus,
    output logic [1:0]        mirror_mode,
    output logic              irq_wr,
    output logic [1:0]        irq_sel,
    output logic [7:0]        irq_wdata
);
    logic              reg_wr;
    logic [SLOT_W-1:0] reg_slot;
    logic              ram_win;
    logic              ram_access;
    logic              tmr_hit;
    map_state_t        state_q;
    logic [SLOT_W-1:0] tmr_off;

    prg_map_decode u_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_addr   (cpu_addr),
        .cpu_wr     (cpu_wr),
        .cpu_rd     (cpu_rd),
        .reg_wr     (reg_wr),
        .reg_slot   (reg_slot),
        .ram_win    (ram_win),
        .ram_access (ram_access),
        .tmr_hit    (tmr_hit)
    );

    prg_map_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_wr   (reg_wr),
        .reg_slot (reg_slot),
        .wdata    (cpu_wdata),
        .state_q  (state_q)
    );

    prg_map_addr u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .state_q  (state_q),
        .cpu_addr (cpu_addr),
        .rom_addr (rom_addr)
    );

    always_comb begin
        tmr_off     = reg_slot - SLOT_TMR_CTRL;
        wram_cs     = ram_access && state_q.wram_on;
        open_bus    = ram_win && cpu_rd && !state_q.wram_on;
        mirror_mode = state_q.mirror;
        irq_wr      = tmr_hit;
        irq_sel     = tmr_hit ? tmr_off[1:0] : 2'd0;
        irq_wdata   = cpu_wdata;
    end

    // R8: select and open-bus never together
    a_r8_cs_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(wram_cs && open_bus));
    // R11: timer slot index stays in range
    a_r11_sel_range: assert property (@(posedge clk) disable iff (!rst_n)
        irq_wr |-> irq_sel != 2'd3);
endmodule

// File: tb/prg_bank_mapper_tb.sv
module prg_bank_mapper_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_wr = 0;
    logic        cpu_rd = 0;
    logic [18:0] rom_addr;
    logic        wram_cs, open_bus, irq_wr;
    logic [1:0]  mirror_mode, irq_sel;
    logic [7:0]  irq_wdata;

    int n_tests = 0;
    int n_fail  = 0;

    logic       m_outer;
    logic [3:0] m_inner;
    logic [1:0] m_mir;
    logic       m_ram;

    always #(CLK_PERIOD/2) clk = ~clk;

    prg_bank_mapper dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .rom_addr(rom_addr), .wram_cs(wram_cs),
        .open_bus(open_bus), .mirror_mode(mirror_mode), .irq_wr(irq_wr),
        .irq_sel(irq_sel), .irq_wdata(irq_wdata)
    );

    function automatic logic [18:0] exp_rom(input logic [15:0] a);
        logic [3:0] b;
        b = a[14] ? 4'hF : m_inner;
        return {m_outer, b, a[13:0]};
    endfunction

    function automatic logic in_win(input logic [15:0] a);
        return a[15:13] == 3'b011;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_write(input logic [15:0] a, input logic [7:0] d);
        if (a[15]) begin
            if (a[3:2] == 2'b00) m_outer = d[0];
            else if (a[3:0] == 4'h8) m_inner = d[3:0];
            else if (a[3:0] == 4'h9) m_mir = d[1:0];
            else if (a[3:0] == 4'hD) m_ram = d[6];
        end
    endtask

    task automatic do_write(input logic [15:0] a, input logic [7:0] d);
        logic exp_t;
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1; cpu_rd = 0;
        #1;
        exp_t = a[15] && (a[3:0] >= 4'hA) && (a[3:0] <= 4'hC);
        chk("R11 irq_wr", irq_wr, exp_t);
        if (exp_t) begin
            chk("R11 irq_sel", irq_sel, a[3:0] - 4'hA);
            chk("R11 irq_wdata", irq_wdata, d);
        end
        chk("R12 rom_addr old in write cycle", rom_addr, exp_rom(a));
        chk("R8 wram_cs on write", wram_cs, in_win(a) && m_ram);
        @(posedge clk);
        model_write(a, d);
        #1 cpu_wr = 0;
    endtask

    task automatic probe(input string req, input logic [15:0] a, input logic rd);
        @(negedge clk);
        cpu_addr = a; cpu_rd = rd; cpu_wr = 0;
        #1;
        chk(req, rom_addr, exp_rom(a));
        chk("R8 wram_cs", wram_cs, in_win(a) && rd && m_ram);
        chk("R8 open_bus", open_bus, in_win(a) && rd && !m_ram);
        chk("R6 mirror_mode", mirror_mode, m_mir);
        chk("R11 irq_wr idle", irq_wr, 0);
        cpu_rd = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] a;
        logic [7:0]  d;
        void'($urandom(32'd1234));
        m_outer = 0; m_inner = 0; m_mir = 0; m_ram = 0;
        repeat (3) @(posedge clk);
        rst_n = 1;
        // R10 reset state
        probe("R10 bank0 at 0x8000", 16'h8000, 1);
        chk("R10 low bank", rom_addr, 19'h0);
        probe("R10 bank15 at 0xC000", 16'hC000, 1);
        chk("R10 high bank", rom_addr, 19'd15 << 14);
        probe("R10 ram off", 16'h6000, 1);
        chk("R10 open_bus", open_bus, 1);
        // R1 mirrored decode
        do_write(16'hF008, 8'h05);
        probe("R1 aliased inner write", 16'h8123, 1);
        chk("R1 inner 5", rom_addr[17:14], 4'd5);
        // R2 each alias slot
        for (int s = 0; s < 4; s++) begin
            do_write(16'h8000 | 16'(s), 8'h00);
            do_write(16'h8000 | 16'(s), 8'h01);
            probe("R2 outer via slot", 16'hC000, 1);
            chk("R2 high bank 31", rom_addr[18:14], 5'd31);
        end
        // R2 ignored slots
        do_write(16'h8000, 8'h00);
        for (int s = 4; s < 16; s++) begin
            if (s == 4 || s == 5 || s == 6 || s == 7 || s == 14 || s == 15)
                do_write(16'h8000 | 16'(s), 8'hFF);
        end
        probe("R2 ignored slots", 16'h8000, 1);
        chk("R2 outer still 0", rom_addr[18:14], 5'd5);
        // R3 / R4 / R5 block 1
        do_write(16'h8001, 8'h01);
        do_write(16'h8008, 8'hF3);
        probe("R4 low window", 16'hA5A5, 1);
        chk("R4 bank 19", rom_addr[18:14], 5'd19);
        probe("R5 high window", 16'hFFFF, 1);
        // R6 all codes
        for (int m = 0; m < 4; m++) begin
            do_write(16'h8009, 8'hFC | 8'(m));
            probe("R6 mirror code", 16'h8000, 0);
        end
        // R7 / R8 RAM gating
        do_write(16'h7000, 8'hAB);
        do_write(16'h800D, 8'h40);
        probe("R7 ram on read", 16'h7FFF, 1);
        do_write(16'h6001, 8'h12);
        do_write(16'h800D, 8'hBF);
        probe("R7 ram off read", 16'h6000, 1);
        // R9 low-half writes
        do_write(16'h4008, 8'h0A);
        do_write(16'h7FF9, 8'h03);
        do_write(16'h0000, 8'h00);
        probe("R9 no effect", 16'h8000, 1);
        // R11 timer slots
        do_write(16'h800A, 8'h01);
        do_write(16'h9ABB, 8'h34);
        do_write(16'h800C, 8'h12);
        // random mix
        for (int i = 0; i < 500; i++) begin
            a = 16'($urandom);
            if ($urandom_range(0, 2) == 0) a[15:4] = 12'h800;
            d = 8'($urandom);
            do_write(a, d);
            probe("R4/R5 random", 16'($urandom), 1'($urandom));
            probe("R8 random window", {3'b011, 13'($urandom)}, 1'($urandom));
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule